// File: doc/BRIEF.md
# Two-Wire Slave Register Interface

This block lets a host controller reach a small register file over a two-wire serial bus (clock and data, both open-drain). It acts only as a slave. The bus lines are first cleaned up by a synchroniser and a majority filter. From the filtered lines the block detects START, repeated START and STOP. It then decodes the transfers and turns them into one-cycle register strobes on a plain parallel port. Bus rates of 100 kHz and 400 kHz are supported, provided the system clock runs at least ten times faster than the bus.

The slave address byte carries three parts. A 4-bit device type sits in bits 7:4, and one select pin picks either 1000b or 1100b. Three address pins are compared against bits 3:1. Bit 0 gives the direction. With two types and eight pin settings, up to 16 of these slaves can share one bus.

A write transfer carries three bytes: the slave address, the register index and the data. A read sets the index the same way, then sends a repeated START and the slave address with the read bit set. After that the slave sends the data. Transfers may run on for any number of bytes. The internal index advances by one for each byte and wraps from 0xFF to 0x00.

Top module: `twi_reg_slave`

## Requirements
- R1: While reset is asserted, `sda_oe` is 0 and both `reg_wr_en` and `reg_rd_en` are 0.
- R2: A slave address byte is acknowledged (SDA pulled low during the ninth clock) only when bits 7:4 equal 1000b (with `type_sel`=0) or 1100b (with `type_sel`=1), and bits 3:1 equal `addr_pins`. Bit 0 selects the direction: 0 for write, 1 for read.
- R3: After a mismatching address byte, the slave acknowledges nothing and issues no write strobe until the next START. This holds even if later bytes look like a valid address.
- R4: In a write, the byte after the address byte sets the register index. Each later byte produces exactly one single-cycle `reg_wr_en` pulse, carrying `reg_addr` and `reg_wdata`. The pulse occurs while SCL is high during that byte's acknowledge clock.
- R5: In a read, the slave pulses `reg_rd_en` and samples `reg_rdata` in that same cycle. It shifts the byte out MSB first, changing SDA only while SCL is low, and leaves SDA released during the master's acknowledge bit.
- R6: In both directions, the register index advances by one after every data byte. It wraps from 0xFF to 0x00.
- R7: If the master answers a read byte with NACK, the slave stops driving SDA and stays silent until a START or STOP.
- R8: Both bus inputs pass through a two-flop synchroniser and a 3-sample majority filter. As a result, a one-system-clock glitch on SCL or SDA has no effect on a transfer.
- R9: A STOP returns the slave to idle with SDA released. A START or repeated START always restarts address-byte reception, and the register index is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus rate |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Bus clock line as seen on the pad |
| sda_in | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_pins | input | 3 | Board-strapped address, compared with address bits 3:1 |
| type_sel | input | 1 | Device-type choice: 0 = 1000b, 1 = 1100b |
| reg_addr | output | 8 | Current register index |
| reg_wdata | output | 8 | Write data, valid with `reg_wr_en` |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_rd_en | output | 1 | One-cycle read strobe; `reg_rdata` is sampled in this cycle |
| reg_rdata | input | 8 | Read data for `reg_addr` |

## Verification
A table walks address bytes over both type codes and several pin settings. Each entry is either a correct match or wrong in exactly one field, the type nibble or the pin bits. This separates the type comparison from the pin comparison. Every accepted entry is then read back through a repeated-START read, which shows that writes and reads reach the same index. Directed runs cover:
- multi-byte writes and reads across the 0xFF index boundary;
- a NACK-terminated read;
- a rejected address followed by a byte that would have matched;
- a STOP and a repeated START in the middle of a transfer;
- bytes clocked with one-cycle glitches on both lines, which separates a working filter from a raw edge detector.

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter logic [3:0] TYPE_LO = 4'b1000,
  parameter logic [3:0] TYPE_HI = 4'b1100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [2:0] addr_pins,
  input  logic       type_sel,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_wr_en,
  output logic       reg_rd_en,
  input  logic [7:0] reg_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {B_DEV, B_REG, B_DATA} kind_t;

  logic [1:0] scl_sync, sda_sync;
  logic [2:0] scl_win, sda_win;
  logic       scl_f, sda_f, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_win  <= '1;
      sda_win  <= '1;
      scl_f    <= 1'b1;
      sda_f    <= 1'b1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_win  <= {scl_win[1:0], scl_sync[1]};
      sda_win  <= {sda_win[1:0], sda_sync[1]};
      scl_f    <= (scl_win[0] & scl_win[1]) | (scl_win[0] & scl_win[2]) | (scl_win[1] & scl_win[2]);
      sda_f    <= (sda_win[0] & sda_win[1]) | (sda_win[0] & sda_win[2]) | (sda_win[1] & sda_win[2]);
      scl_d    <= scl_f;
      sda_d    <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_d;
  wire scl_fall = ~scl_f & scl_d;
  wire start_c  = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_c   = scl_f & scl_d & ~sda_d & sda_f;

  st_t        st;
  kind_t      kind;
  logic       rw, mack_ok;
  logic [3:0] cnt;
  logic [7:0] sh, tx, ptr;

  wire [3:0] want_type = type_sel ? TYPE_HI : TYPE_LO;
  wire       id_ok     = (sh[7:4] == want_type) && (sh[3:1] == addr_pins);

  assign reg_addr  = ptr;
  assign reg_wdata = sh;
  assign reg_wr_en = (st == S_ACK) && (kind == B_DATA) && !rw && scl_rise && !start_c && !stop_c;
  assign reg_rd_en = scl_fall && (((st == S_ACK) && (kind == B_DEV) && rw) ||
                                  ((st == S_MACK) && mack_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind    <= B_DEV;
      rw      <= 1'b0;
      mack_ok <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (start_c) begin
      st     <= S_RX;
      kind   <= B_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_f};
            cnt <= cnt + 4'd1;
          end
          if (scl_fall && cnt == 4'd8) begin
            case (kind)
              B_DEV: begin
                if (id_ok) begin
                  rw     <= sh[0];
                  st     <= S_ACK;
                  sda_oe <= 1'b1;
                end else begin
                  st <= S_IDLE;
                end
              end
              B_REG: begin
                ptr    <= sh;
                st     <= S_ACK;
                sda_oe <= 1'b1;
              end
              default: begin
                st     <= S_ACK;
                sda_oe <= 1'b1;
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (kind == B_DEV && rw) begin
              tx     <= reg_rdata;
              sda_oe <= ~reg_rdata[7];
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_RX;
              kind   <= (kind == B_DEV) ? B_REG : B_DATA;
              if (kind == B_DATA) ptr <= ptr + 8'd1;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              st     <= S_MACK;
              sda_oe <= 1'b0;
              ptr    <= ptr + 8'd1;
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
              cnt    <= cnt + 4'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) mack_ok <= ~sda_f;
          if (scl_fall) begin
            if (mack_ok) begin
              tx     <= reg_rdata;
              sda_oe <= ~reg_rdata[7];
              cnt    <= '0;
              st     <= S_TX;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic wr,
  input logic rd,
  input logic oe,
  input logic idle
);
  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) wr |=> !wr);
  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rd |=> !rd);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(wr && rd));
  // R5
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(oe) |-> !$past(scl_f));
  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n) idle |-> !oe);
endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .wr(reg_wr_en),
  .rd(reg_rd_en), .oe(sda_oe), .idle(st == S_IDLE)
);

// File: tb/twi_reg_slave_test.sv
module twi_reg_slave_test;
  localparam int Q = 10;
  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic [2:0] addr_pins = 0;
  logic type_sel = 0;
  logic sda_oe, reg_wr_en, reg_rd_en;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  int checks = 0, errors = 0, wr_cnt = 0, wr_bad = 0;
  logic done = 0;
  logic glitch = 0;

  wire sda_bus = sda_m & ~sda_oe;
  wire scl_bus = scl_m & ~glitch;

  always #2 clk = ~clk;

  twi_reg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus), .sda_oe(sda_oe),
    .addr_pins(addr_pins), .type_sel(type_sel), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_wr_en) begin
    mem[reg_addr] <= reg_wdata;
    wr_cnt <= wr_cnt + 1;
    if (!scl_m) wr_bad <= wr_bad + 1;
  end

  // {sel, pins, dev, reg, data, expect_ack}
  localparam logic [28:0] VEC [8] = '{
    {1'b0, 3'd5, 8'h8A, 8'h10, 8'h3C, 1'b1},
    {1'b1, 3'd2, 8'hC4, 8'h20, 8'hA5, 1'b1},
    {1'b0, 3'd5, 8'hCA, 8'h11, 8'h66, 1'b0},
    {1'b1, 3'd2, 8'h84, 8'h21, 8'h67, 1'b0},
    {1'b0, 3'd3, 8'h86, 8'hFF, 8'h5A, 1'b1},
    {1'b0, 3'd3, 8'h82, 8'h12, 8'h68, 1'b0},
    {1'b1, 3'd7, 8'hCE, 8'h00, 8'hFF, 1'b1},
    {1'b1, 3'd0, 8'hC0, 8'h7F, 8'h00, 1'b1}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; qwait(); scl_m = 1; qwait(); sda_m = 0; qwait(); scl_m = 0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 0; qwait(); scl_m = 1; qwait(); sda_m = 1; qwait();
  endtask

  task automatic bit_out(input logic b, input logic g, output logic s);
    sda_m = b; qwait(); scl_m = 1; qwait();
    if (g) begin
      glitch = 1; @(negedge clk); glitch = 0;
      repeat (3) @(negedge clk);
      sda_m = ~b; @(negedge clk); sda_m = b;
    end
    s = sda_bus; qwait(); scl_m = 0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic g, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_out(b[i], g, s);
    bit_out(1'b1, 1'b0, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b, output logic ack_line);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_out(1'b1, 1'b0, s);
      b[i] = s;
    end
    bit_out(!mack, 1'b0, s);
    ack_line = s;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %h expected %h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a1, a2, a3, a4, ln;
    logic [7:0] rb;
    int w0;
    repeat (5) @(negedge clk);
    chk(sda_oe == 0 && !reg_wr_en && !reg_rd_en, "R1 reset outputs",
        {sda_oe, reg_wr_en, reg_rd_en}, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      logic [28:0] e;
      e = VEC[v];
      type_sel = e[28]; addr_pins = e[27:25];
      w0 = wr_cnt;
      bus_start();
      send_byte(e[24:17], 0, a1);
      send_byte(e[16:9], 0, a2);
      send_byte(e[8:1], 0, a3);
      bus_stop();
      @(negedge clk);
      chk(a1 == e[0], e[0] ? "R2 address match ack" : "R3 address mismatch nack", a1, e[0]);
      if (e[0]) begin
        chk(a2 && a3, "R4 index/data acked", {a2, a3}, 2'b11);
        chk(wr_cnt == w0 + 1, "R4 one write strobe", wr_cnt - w0, 1);
        chk(mem[e[16:9]] == e[8:1], "R4 written value", mem[e[16:9]], e[8:1]);
        bus_start();
        send_byte(e[24:17], 0, a1);
        send_byte(e[16:9], 0, a2);
        bus_start();
        send_byte(e[24:17] | 8'h01, 0, a3);
        recv_byte(0, rb, ln);
        bus_stop();
        chk(a3, "R2 read address ack", a3, 1);
        chk(rb == e[8:1], "R5 read back", rb, e[8:1]);
        chk(ln == 1, "R5 sda released in master ack bit", ln, 1);
      end else begin
        chk(!a2 && !a3, "R3 later bytes not acked", {a2, a3}, 0);
        chk(wr_cnt == w0, "R3 no write strobe", wr_cnt - w0, 0);
      end
    end

    type_sel = 0; addr_pins = 3'd5;
    bus_start();
    send_byte(8'h8A, 0, a1); send_byte(8'hFE, 0, a1);
    send_byte(8'h11, 0, a1); send_byte(8'h22, 0, a2); send_byte(8'h33, 0, a3);
    bus_stop();
    chk(mem[8'hFE] == 8'h11 && mem[8'hFF] == 8'h22, "R6 sequential write", {mem[8'hFE], mem[8'hFF]}, 16'h1122);
    chk(mem[8'h00] == 8'h33, "R6 index wraps to 00", mem[8'h00], 8'h33);

    bus_start();
    send_byte(8'h8A, 0, a1); send_byte(8'hFE, 0, a1);
    bus_start();
    send_byte(8'h8B, 0, a1);
    recv_byte(1, rb, ln);
    chk(rb == 8'h11, "R6 read byte 0", rb, 8'h11);
    recv_byte(1, rb, ln);
    chk(rb == 8'h22, "R6 read byte 1", rb, 8'h22);
    recv_byte(0, rb, ln);
    chk(rb == 8'h33, "R6 read wraps", rb, 8'h33);
    repeat (Q) @(negedge clk);
    chk(sda_oe == 0, "R7 released after nack", sda_oe, 0);
    recv_byte(0, rb, ln);
    chk(rb == 8'hFF, "R7 silent after nack", rb, 8'hFF);
    bus_stop();

    bus_start();
    send_byte(8'h8A, 0, a1);
    bus_stop();
    chk(sda_oe == 0, "R9 stop releases", sda_oe, 0);
    w0 = wr_cnt;
    bus_start();
    send_byte(8'h8A, 0, a1); send_byte(8'h31, 0, a1);
    bus_start();
    send_byte(8'h8A, 0, a1); send_byte(8'h32, 0, a2); send_byte(8'h88, 0, a3);
    bus_stop();
    chk(a1 && a3 && mem[8'h32] == 8'h88 && wr_cnt == w0 + 1, "R9 repeated start restarts address",
        mem[8'h32], 8'h88);

    w0 = wr_cnt;
    bus_start();
    send_byte(8'h9A, 0, a1); send_byte(8'h8A, 0, a2); send_byte(8'h44, 0, a3);
    bus_stop();
    chk(!a1 && !a2 && !a3 && wr_cnt == w0, "R3 ignored until next start", {a1, a2, a3}, 0);

    bus_start();
    send_byte(8'h8A, 1, a1); send_byte(8'h50, 1, a2); send_byte(8'h3E, 1, a3);
    bus_stop();
    chk(a1 && a2 && a3 && mem[8'h50] == 8'h3E, "R8 glitches filtered", mem[8'h50], 8'h3E);

    chk(wr_bad == 0, "R4 write strobe while scl high", wr_bad, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule